// File: doc/BRIEF.md
# Multi-Sequence Command Store and Sequencer

This block keeps a table of 32-bit command words in one region of a shared on-chip SRAM and plays them back in order. A host fills the region one word at a time. It first latches a destination word address, then writes the command content, which is stored at the latched address. The usable size of the region is chosen from the shared SRAM in units of 512 words: one, two or three units. Writes that fall outside the chosen size are dropped.

Four sequence descriptors, each holding a start address and a command count, index into the region. When the host raises a start request for one descriptor, the sequencer reads that descriptor's commands one by one. It presents each command on a valid/ready handshake to the downstream executor. The control enable input governs the end of a run: the end-of-sequence interrupt is produced only once the final command has been accepted and the enable is low. If a command waits too long for acceptance, the sequence is aborted and a timeout interrupt is pulsed. Descriptors may overlap freely. Nothing checks or reports an overlap.

The sequencer has four states. IDLE waits for a start request. FETCH issues one SRAM read. PRESENT holds the command valid until it is accepted or the timeout expires. FINISH waits for the enable to be low and then pulses end-of-sequence. Transitions: IDLE to FETCH on a start with a non-zero count. IDLE to FINISH on a start with a zero count. FETCH to PRESENT always. PRESENT to FETCH on acceptance of a command that is not the last. PRESENT to FINISH on acceptance of the last command. PRESENT to IDLE on timeout. FINISH to IDLE when the enable is low.

Top module: `cmdseq_top`

## Requirements
- R1: After reset, cmd_valid, busy, eos_irq and timeout_irq are all low.
- R2: A pulse on host_addr_we latches host_addr. A pulse on host_data_we stores host_data at the latched address. The address stays latched, so a second data write without a new address write overwrites the same word.
- R3: size_sel selects the region size: 0 gives 512 words, 1 gives 1024, 2 gives 1536, and any other value gives 512. A host data write to an address at or above the size is dropped. A fetch from an address at or above the size returns zero.
- R4: A descriptor word written with desc_we into slot desc_sel (0 to 3) takes the start address from bits [10:0] and the command count from bits [26:16]. All other bits are ignored.
- R5: After a start request for slot start_sel, the commands at start, start+1, and onward up to count words are presented in address order. Each one is held on cmd_valid until it is accepted with cmd_ready.
- R6: While cmd_valid is high and cmd_ready is low, cmd_data does not change.
- R7: With seq_en low, eos_irq pulses high for exactly one cycle after the final command is accepted, and busy is low in that cycle.
- R8: If seq_en is high when the final command is accepted, busy stays high and eos_irq stays low until seq_en goes low. eos_irq then pulses in the next cycle.
- R9: A start request for a descriptor with a count of zero presents no command and produces the end-of-sequence pulse.
- R10: A start request that arrives while busy is high is ignored. Only the running sequence's commands are presented.
- R11: If cmd_valid stays high for TIMEOUT_CYC consecutive cycles without cmd_ready, cmd_valid drops and timeout_irq pulses for one cycle. busy goes low and no eos_irq follows.
- R12: Overlapping descriptors each fetch the shared words unchanged, and nothing flags the overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| size_sel | input | 3 | Command region size select |
| host_addr_we | input | 1 | Latch host_addr as the write address |
| host_addr | input | 11 | Word address for the next command write |
| host_data_we | input | 1 | Store host_data at the latched address |
| host_data | input | 32 | Command word content |
| desc_we | input | 1 | Write a descriptor word |
| desc_sel | input | 2 | Descriptor slot being written |
| desc_word | input | 32 | Descriptor word: start [10:0], count [26:16] |
| seq_en | input | 1 | Control enable; must be low for end-of-sequence |
| start_req | input | 1 | Start the selected sequence |
| start_sel | input | 2 | Descriptor slot to start |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Command accepted by the executor |
| cmd_data | output | 32 | Presented command word |
| busy | output | 1 | A sequence is in progress |
| active_sel | output | 2 | Slot of the most recently started sequence |
| eos_irq | output | 1 | End-of-sequence pulse |
| timeout_irq | output | 1 | Command acceptance timeout pulse |

## Verification
The hardest case to reach from the ports is a fetch that runs past the end of the region. It needs a sequence that crosses the size boundary while the host has already written data beyond that boundary. The bench loads words above 512 under the 1024-word setting, then switches to 512 words and replays the same range, so the upper half must read as zero. Dropped writes need a similar trick. A word is written under the larger size, overwritten under the smaller size, and then read back after the larger size is restored. The timeout and held-enable endings are reached by withholding cmd_ready, or keeping seq_en high, for a counted number of cycles.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int SEQ_ADDR_W = 11;
    localparam int SEQ_CNT_W  = 11;
    localparam int CNT_LSB    = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PRESENT,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic [SEQ_CNT_W-1:0]  count;
        logic [SEQ_ADDR_W-1:0] start;
    } seq_desc_t;

endpackage

// File: rtl/cmdseq_desc_bank.sv
module cmdseq_desc_bank
    import cmdseq_pkg::*;
#(
    parameter int N_SEQ  = 4,
    parameter int WORD_W = 32,
    localparam int SEL_W = $clog2(N_SEQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [SEL_W-1:0]  rd_sel,
    output seq_desc_t         rd_desc
);

    seq_desc_t slot_q [N_SEQ];
    seq_desc_t decoded;

    // Fields of the descriptor word; the remaining bits carry no meaning.
    always_comb begin
        decoded.start = wr_word[SEQ_ADDR_W-1:0];
        decoded.count = wr_word[CNT_LSB +: SEQ_CNT_W];
    end

    for (genvar g = 0; g < N_SEQ; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                slot_q[g] <= decoded;
            end
        end
    end

    assign rd_desc = slot_q[rd_sel];

endmodule

// File: rtl/cmdseq_store.sv
module cmdseq_store #(
    parameter int UNIT_WORDS = 512,
    parameter int N_UNITS    = 3,
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 32,
    parameter int SIZE_W     = 3,
    localparam int DEPTH     = UNIT_WORDS * N_UNITS,
    localparam int LIM_W     = ADDR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] size_sel,
    input  logic              haddr_we,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hdata_we,
    input  logic [DATA_W-1:0] hdata,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr_q;
    logic [LIM_W-1:0]  limit;
    logic              wr_ok;
    logic              rd_ok;

    // Region size in words, a whole number of units; unknown codes fall back to one unit.
    always_comb begin
        limit = LIM_W'(UNIT_WORDS);
        for (int u = 1; u < N_UNITS; u++) begin
            if (size_sel == SIZE_W'(u)) begin
                limit = LIM_W'(UNIT_WORDS * (u + 1));
            end
        end
    end

    assign wr_ok = LIM_W'(wr_ptr_q) < limit;
    assign rd_ok = LIM_W'(rd_addr) < limit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
        end else if (haddr_we) begin
            wr_ptr_q <= haddr;
        end
    end

    always_ff @(posedge clk) begin
        if (hdata_we && wr_ok) begin
            mem[wr_ptr_q] <= hdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_ok ? mem[rd_addr[ADDR_W-1:0]] : '0;
        end
    end

endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
    import cmdseq_pkg::*;
#(
    parameter int N_SEQ       = 4,
    parameter int TIMEOUT_CYC = 1024,
    localparam int SEL_W      = $clog2(N_SEQ),
    localparam int TO_W       = $clog2(TIMEOUT_CYC + 1),
    localparam int RA_W       = SEQ_ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [SEL_W-1:0] start_sel,
    input  seq_desc_t        desc,
    input  logic             seq_en,
    input  logic             cmd_ready,
    output logic             rd_en,
    output logic [RA_W-1:0]  rd_addr,
    output logic             cmd_valid,
    output logic             busy,
    output logic [SEL_W-1:0] active_sel,
    output logic             eos_irq,
    output logic             timeout_irq
);

    seq_state_e state_q, state_d;

    logic [SEQ_ADDR_W-1:0] base_q;
    logic [SEQ_CNT_W-1:0]  total_q;
    logic [SEQ_CNT_W-1:0]  idx_q;
    logic [TO_W-1:0]       wait_q;
    logic                  last_cmd;
    logic                  wait_hit;

    assign last_cmd = (idx_q == total_q - SEQ_CNT_W'(1));
    assign wait_hit = (wait_q == TO_W'(TIMEOUT_CYC - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    state_d = (desc.count == '0) ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FETCH: begin
                state_d = ST_PRESENT;
            end
            ST_PRESENT: begin
                if (cmd_ready) begin
                    state_d = last_cmd ? ST_FINISH : ST_FETCH;
                end else if (wait_hit) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FINISH: begin
                if (!seq_en) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= '0;
            total_q     <= '0;
            idx_q       <= '0;
            wait_q      <= '0;
            active_sel  <= '0;
            eos_irq     <= 1'b0;
            timeout_irq <= 1'b0;
        end else begin
            eos_irq     <= 1'b0;
            timeout_irq <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        base_q     <= desc.start;
                        total_q    <= desc.count;
                        idx_q      <= '0;
                        active_sel <= start_sel;
                    end
                end
                ST_FETCH: begin
                    wait_q <= '0;
                end
                ST_PRESENT: begin
                    if (cmd_ready) begin
                        idx_q  <= idx_q + SEQ_CNT_W'(1);
                        wait_q <= '0;
                    end else if (wait_hit) begin
                        timeout_irq <= 1'b1;
                        wait_q      <= '0;
                    end else begin
                        wait_q <= wait_q + TO_W'(1);
                    end
                end
                ST_FINISH: begin
                    if (!seq_en) begin
                        eos_irq <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_en     = (state_q == ST_FETCH);
    assign rd_addr   = RA_W'(base_q) + RA_W'(idx_q);
    assign cmd_valid = (state_q == ST_PRESENT);
    assign busy      = (state_q != ST_IDLE);

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
    import cmdseq_pkg::*;
#(
    parameter int N_SEQ       = 4,
    parameter int UNIT_WORDS  = 512,
    parameter int N_UNITS     = 3,
    parameter int DATA_W      = 32,
    parameter int SIZE_W      = 3,
    parameter int TIMEOUT_CYC = 1024,
    localparam int SEL_W      = $clog2(N_SEQ)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SIZE_W-1:0]     size_sel,
    input  logic                  host_addr_we,
    input  logic [SEQ_ADDR_W-1:0] host_addr,
    input  logic                  host_data_we,
    input  logic [DATA_W-1:0]     host_data,
    input  logic                  desc_we,
    input  logic [SEL_W-1:0]      desc_sel,
    input  logic [31:0]           desc_word,
    input  logic                  seq_en,
    input  logic                  start_req,
    input  logic [SEL_W-1:0]      start_sel,
    output logic                  cmd_valid,
    input  logic                  cmd_ready,
    output logic [DATA_W-1:0]     cmd_data,
    output logic                  busy,
    output logic [SEL_W-1:0]      active_sel,
    output logic                  eos_irq,
    output logic                  timeout_irq
);

    seq_desc_t             sel_desc;
    logic                  rd_en;
    logic [SEQ_ADDR_W:0]   rd_addr;

    cmdseq_desc_bank #(
        .N_SEQ  (N_SEQ),
        .WORD_W (32)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (desc_we),
        .wr_sel  (desc_sel),
        .wr_word (desc_word),
        .rd_sel  (start_sel),
        .rd_desc (sel_desc)
    );

    cmdseq_store #(
        .UNIT_WORDS (UNIT_WORDS),
        .N_UNITS    (N_UNITS),
        .ADDR_W     (SEQ_ADDR_W),
        .DATA_W     (DATA_W),
        .SIZE_W     (SIZE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .size_sel (size_sel),
        .haddr_we (host_addr_we),
        .haddr    (host_addr),
        .hdata_we (host_data_we),
        .hdata    (host_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (cmd_data)
    );

    cmdseq_fsm #(
        .N_SEQ       (N_SEQ),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .start_sel   (start_sel),
        .desc        (sel_desc),
        .seq_en      (seq_en),
        .cmd_ready   (cmd_ready),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .cmd_valid   (cmd_valid),
        .busy        (busy),
        .active_sel  (active_sel),
        .eos_irq     (eos_irq),
        .timeout_irq (timeout_irq)
    );

endmodule

// File: rtl/cmdseq_chk.sv
module cmdseq_chk #(
    parameter int DATA_W      = 32,
    parameter int TIMEOUT_CYC = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seq_en,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [DATA_W-1:0] cmd_data,
    input logic              busy,
    input logic              eos_irq,
    input logic              timeout_irq
);

    int unsigned stall_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_cnt <= 0;
        end else if (cmd_valid && !cmd_ready) begin
            stall_cnt <= stall_cnt + 1;
        end else begin
            stall_cnt <= 0;
        end
    end

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (!cmd_valid || $stable(cmd_data)));

    // R10
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    // R7
    eos_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos_irq |=> !eos_irq);

    // R7
    eos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos_irq |-> (!busy && !cmd_valid));

    // R8
    eos_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eos_irq) |-> !$past(seq_en));

    // R11
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eos_irq, timeout_irq}));

    // R11
    stall_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_cnt <= TIMEOUT_CYC);

    // R11
    timeout_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_irq |-> (!cmd_valid && !busy));

endmodule

bind cmdseq_top cmdseq_chk #(
    .DATA_W      (DATA_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_en      (seq_en),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_data    (cmd_data),
    .busy        (busy),
    .eos_irq     (eos_irq),
    .timeout_irq (timeout_irq)
);

// File: tb/test_cmdseq_top.sv
`timescale 1ns/1ps
module test_cmdseq_top;

    localparam int TO_CYC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  size_sel = '0;
    logic        host_addr_we = 1'b0;
    logic [10:0] host_addr = '0;
    logic        host_data_we = 1'b0;
    logic [31:0] host_data = '0;
    logic        desc_we = 1'b0;
    logic [1:0]  desc_sel = '0;
    logic [31:0] desc_word = '0;
    logic        seq_en = 1'b0;
    logic        start_req = 1'b0;
    logic [1:0]  start_sel = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_data;
    logic        busy;
    logic [1:0]  active_sel;
    logic        eos_irq;
    logic        timeout_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cmdseq_top #(.TIMEOUT_CYC(TO_CYC)) i_cmdseq_top (
        .clk(clk), .rst_n(rst_n), .size_sel(size_sel),
        .host_addr_we(host_addr_we), .host_addr(host_addr),
        .host_data_we(host_data_we), .host_data(host_data),
        .desc_we(desc_we), .desc_sel(desc_sel), .desc_word(desc_word),
        .seq_en(seq_en), .start_req(start_req), .start_sel(start_sel),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .busy(busy), .active_sel(active_sel), .eos_irq(eos_irq),
        .timeout_irq(timeout_irq)
    );

    // columns: slot, start, count, ready gap, size code
    localparam int VEC [6][5] = '{
        '{0,   0,  5, 0, 0},
        '{1,  10,  8, 2, 0},
        '{2, 500, 20, 1, 0},
        '{3, 500, 20, 0, 1},
        '{1,   3,  4, 3, 2},
        '{0,   0,  1, 0, 2}
    };

    function automatic logic [31:0] pat(int a);
        return 32'hC300_0000 ^ (32'(a) << 12) ^ 32'(a + 1);
    endfunction

    function automatic int limit_of(int code);
        return (code == 1) ? 1024 : (code == 2) ? 1536 : 512;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(int a, logic [31:0] d);
        @(negedge clk); host_addr_we = 1'b1; host_addr = 11'(a);
        @(negedge clk); host_addr_we = 1'b0; host_data_we = 1'b1; host_data = d;
        @(negedge clk); host_data_we = 1'b0;
    endtask

    task automatic host_data_only(logic [31:0] d);
        @(negedge clk); host_data_we = 1'b1; host_data = d;
        @(negedge clk); host_data_we = 1'b0;
    endtask

    task automatic set_desc(int slot, int st, int cnt);
        @(negedge clk);
        desc_we = 1'b1; desc_sel = 2'(slot);
        desc_word = {5'h1F, 11'(cnt), 5'h1F, 11'(st)};
        @(negedge clk); desc_we = 1'b0;
    endtask

    task automatic pulse_start(int slot);
        @(negedge clk); start_req = 1'b1; start_sel = 2'(slot);
        @(negedge clk); start_req = 1'b0;
    endtask

    // Runs one sequence, checking every word, the count and the end pulse.
    task automatic run_seq(int slot, int st, int cnt, int gap, int code, string tag);
        int got = 0;
        int eos_n = 0;
        int to_n = 0;
        int ph = 0;
        int quiet = 0;
        bit prev_wait = 0;
        logic [31:0] prev_d = '0;
        size_sel = 3'(code);
        set_desc(slot, st, cnt);
        pulse_start(slot);
        for (int c = 0; c < 4000 && quiet < 4; c++) begin
            bit rdy;
            @(negedge clk);
            if (eos_irq) eos_n++;
            if (timeout_irq) to_n++;
            if (eos_n > 0 && !busy) quiet++;
            rdy = (ph == gap);
            ph = (ph == gap) ? 0 : ph + 1;
            if (cmd_valid && prev_wait) begin
                chk(cmd_data == prev_d, "R6", cmd_data, prev_d);
            end
            if (cmd_valid && rdy) begin
                int a = st + got;
                logic [31:0] e = (a < limit_of(code)) ? pat(a) : 32'h0;
                chk(cmd_data == e, (a < limit_of(code)) ? tag : "R3", cmd_data, e);
                got++;
            end
            prev_wait = cmd_valid && !rdy;
            prev_d = cmd_data;
            cmd_ready = rdy;
        end
        cmd_ready = 1'b0;
        chk(got == cnt, "R4", 32'(got), 32'(cnt));
        chk(eos_n == 1 && to_n == 0, "R7", 32'(eos_n), 32'd1);
        chk(active_sel == 2'(slot), "R4", 32'(active_sel), 32'(slot));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!cmd_valid, "R1", 32'(cmd_valid), 32'd0);
        chk(!busy, "R1", 32'(busy), 32'd0);
        chk(!eos_irq && !timeout_irq, "R1", 32'({eos_irq, timeout_irq}), 32'd0);
        rst_n = 1'b1;

        size_sel = 3'd1;
        for (int a = 0; a < 64; a++) host_write(a, pat(a));
        for (int a = 496; a < 536; a++) host_write(a, pat(a));

        // R5 R3 R12 vector table
        for (int i = 0; i < 6; i++) begin
            run_seq(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4],
                    (i == 4) ? "R12" : "R5");
        end

        // R9 zero count
        begin
            int v = 0;
            int e = 0;
            set_desc(2, 7, 0);
            pulse_start(2);
            cmd_ready = 1'b1;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (cmd_valid) v++;
                if (eos_irq) e++;
            end
            cmd_ready = 1'b0;
            chk(v == 0, "R9", 32'(v), 32'd0);
            chk(e == 1, "R9", 32'(e), 32'd1);
        end

        // R10 start while busy
        begin
            int got = 0;
            int late = 0;
            set_desc(0, 0, 3);
            set_desc(1, 20, 8);
            pulse_start(0);
            repeat (2) @(negedge clk);
            start_req = 1'b1; start_sel = 2'd1;
            @(negedge clk); start_req = 1'b0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (cmd_valid) begin
                    chk(cmd_data == pat(got), "R10", cmd_data, pat(got));
                    got++;
                end
                cmd_ready = cmd_valid;
                if (c > 20 && (busy || cmd_valid)) late++;
            end
            cmd_ready = 1'b0;
            chk(got == 3, "R10", 32'(got), 32'd3);
            chk(late == 0, "R10", 32'(late), 32'd0);
        end

        // R8 enable held high at completion
        begin
            int got = 0;
            seq_en = 1'b1;
            set_desc(3, 5, 2);
            pulse_start(3);
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (cmd_valid) got++;
                cmd_ready = cmd_valid;
            end
            cmd_ready = 1'b0;
            chk(got == 2, "R8", 32'(got), 32'd2);
            chk(busy && !eos_irq, "R8", 32'({busy, eos_irq}), 32'h2);
            seq_en = 1'b0;
            @(negedge clk);
            chk(eos_irq && !busy, "R8", 32'({eos_irq, busy}), 32'h2);
            @(negedge clk);
            chk(!eos_irq, "R7", 32'(eos_irq), 32'd0);
        end

        // R11 timeout
        begin
            int hold = 0;
            int tos = 0;
            int eos = 0;
            set_desc(2, 0, 4);
            pulse_start(2);
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (cmd_valid) hold++;
                if (timeout_irq) begin
                    tos++;
                    chk(!busy && !cmd_valid, "R11", 32'({busy, cmd_valid}), 32'd0);
                end
                if (eos_irq) eos++;
            end
            chk(hold == TO_CYC, "R11", 32'(hold), 32'(TO_CYC));
            chk(tos == 1 && eos == 0, "R11", 32'({tos[15:0], eos[15:0]}), 32'h0001_0000);
        end

        // R2 and R3: dropped write above the region, latched address reuse
        size_sel = 3'd1;
        host_write(515, 32'hAAAA_0515);
        size_sel = 3'd0;
        host_write(515, 32'hBBBB_0515);
        size_sel = 3'd1;
        host_write(40, 32'h1111_0040);
        host_data_only(32'h2222_0040);
        begin
            set_desc(2, 515, 1);
            pulse_start(2);
            cmd_ready = 1'b1;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (cmd_valid) chk(cmd_data == 32'hAAAA_0515, "R3", cmd_data, 32'hAAAA_0515);
            end
            set_desc(3, 40, 1);
            pulse_start(3);
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (cmd_valid) chk(cmd_data == 32'h2222_0040, "R2", cmd_data, 32'h2222_0040);
            end
            cmd_ready = 1'b0;
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule